// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which transmit mailbox of a CAN controller is passed to the bit-level serializer next. It holds a bank of mailboxes. Each mailbox has a control word with three fields: a priority value, a payload length code and a remote-request flag. Each mailbox also has one bit in each of five registers: enable, direction, pending, acknowledge and interrupt mask. Software fills the control words, enables the mailboxes and then marks them pending through a write-one-to-set port.

While the serializer is idle, a comparison tree picks the winner among the mailboxes that are pending, enabled and set to transmit. A larger priority value wins. When two mailboxes have the same priority, the one with the higher index wins. The arbiter registers the winning index and holds it on the serializer interface until the serializer reports completion or abandonment. On completion the pending bit is cleared and the acknowledge bit is set on the same edge. Software clears acknowledge bits by writing ones, and the mailbox interrupt is raised while any unmasked acknowledge bit is set.

Top module: `tx_mbox_arbiter`

## Requirements
- R1: A mailbox is eligible only when its pending bit is 1, its enable bit is 1 and its direction bit is 0 (direction 1 means receive). A mailbox that is not eligible is never presented, and its pending bit is kept.
- R2: Among eligible mailboxes, the one with the largest 6-bit priority value is presented. The priority is control-word bits 13:8.
- R3: When eligible mailboxes have equal priority, the one with the higher index is presented.
- R4: Writing req_set_data sets the pending bit of every mailbox whose data bit is 1. Zero data bits change nothing, and a pending bit is never cleared except by completion or abandonment.
- R5: Once ser_valid is high, ser_idx stays constant until ser_done or ser_abort is seen, even when requests with higher priority arrive in the meantime.
- R6: On the edge where ser_done is sampled high with ser_valid high, the presented mailbox's pending bit clears and its acknowledge bit sets, and ser_valid is low in the following cycle. A set request for that same mailbox in that cycle leaves it pending.
- R7: ser_abort (with ser_done low) clears the presented mailbox's pending bit and leaves its acknowledge bit unchanged.
- R8: Writing ack_clr_data clears the acknowledge bits at its one positions. A completion in the same cycle for the same mailbox wins, so that bit ends up set.
- R9: mbx_irq is 1 exactly when some acknowledge bit and the corresponding interrupt mask bit are both 1.
- R10: While ser_valid is high, ser_len equals bits 3:0 and ser_rtr equals bit 4 of the presented mailbox's control word.
- R11: After reset, the enable, direction, mask, pending and acknowledge registers and all control words are zero, and ser_valid and mbx_irq are 0.
- R12: When the arbiter is idle and a mailbox is eligible after clock edge k, ser_valid is high with that winner after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Load enable register |
| en_wdata | input | N_MBOX | Enable register value |
| dir_wr | input | 1 | Load direction register |
| dir_wdata | input | N_MBOX | Direction value, 1 = receive |
| mask_wr | input | 1 | Load interrupt mask register |
| mask_wdata | input | N_MBOX | Interrupt mask value |
| ctrl_wr | input | 1 | Load one control word |
| ctrl_sel | input | IDX_W | Mailbox index of the control word |
| ctrl_wdata | input | 14 | Control word: priority 13:8, remote flag 4, length 3:0 |
| req_set_wr | input | 1 | Write-one-to-set strobe for pending bits |
| req_set_data | input | N_MBOX | Pending bits to set |
| ack_clr_wr | input | 1 | Write-one-to-clear strobe for acknowledge bits |
| ack_clr_data | input | N_MBOX | Acknowledge bits to clear |
| ser_valid | output | 1 | A mailbox is handed to the serializer |
| ser_idx | output | IDX_W | Index of the handed mailbox |
| ser_len | output | 4 | Length code of the handed mailbox |
| ser_rtr | output | 1 | Remote-request flag of the handed mailbox |
| ser_done | input | 1 | Serializer reports successful transmission |
| ser_abort | input | 1 | Serializer reports the frame abandoned |
| pend_o | output | N_MBOX | Pending register |
| ack_o | output | N_MBOX | Acknowledge register |
| mbx_irq | output | 1 | Mailbox interrupt |

## Verification
The assertions assume that ser_done and ser_abort are raised only while ser_valid is high, and that configuration registers are not rewritten in a way that makes them depend on an unfinished selection. The bench keeps to these assumptions as follows. It writes the enable register to zero before it changes direction, mask, control words or requests. It re-enables mailboxes as the last step. It then drains every eligible mailbox before it starts a new round. Completion and abort pulses are driven only in cycles where ser_valid was observed high. Requests that arrive during a hold, and acknowledge clears in the same cycle as a completion, are driven only within those windows.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    // Control word field layout
    localparam int CTRL_W   = 14;
    localparam int LEN_LSB  = 0;
    localparam int LEN_W    = 4;
    localparam int RTR_BIT  = 4;
    localparam int PRIO_LSB = 8;
    localparam int PRIO_W   = 6;
    localparam int SPARE_W  = PRIO_LSB - RTR_BIT - 1;
endpackage

// File: rtl/txarb_select.sv
// Comparison tree: the largest {priority, index} key among eligible mailboxes wins.
module txarb_select
    import txarb_pkg::*;
#(
    parameter int N_MBOX = 32,
    localparam int IDX_W = $clog2(N_MBOX),
    localparam int LVLS  = $clog2(N_MBOX),
    localparam int KEY_W = PRIO_W + IDX_W
) (
    input  logic                           rst_n,
    input  logic [N_MBOX-1:0]              elig,
    input  logic [N_MBOX-1:0][PRIO_W-1:0]  prio,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx
);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int W = N_MBOX >> l;
        logic [W-1:0]            v;
        logic [W-1:0][KEY_W-1:0] keys;
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_in
                assign v[j]    = elig[j];
                assign keys[j] = {prio[j], IDX_W'(j)};
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_cmp
                logic take_hi;
                assign take_hi = g_lvl[l-1].v[2*j+1] &&
                                 (!g_lvl[l-1].v[2*j] ||
                                  (g_lvl[l-1].keys[2*j+1] > g_lvl[l-1].keys[2*j]));
                assign v[j]    = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
                assign keys[j] = take_hi ? g_lvl[l-1].keys[2*j+1] : g_lvl[l-1].keys[2*j];
            end
        end
    end

    assign win_valid = g_lvl[LVLS].v[0];
    assign win_idx   = g_lvl[LVLS].keys[0][IDX_W-1:0];

    // Winner is eligible and no eligible mailbox has a larger key.
    always_comb begin
        if (rst_n && win_valid) begin
            p_win_elig_r1: assert (elig[win_idx]) else $error("winner not eligible");
            for (int j = 0; j < N_MBOX; j++) begin
                p_win_max_r2: assert (!elig[j] ||
                    ({prio[j], IDX_W'(j)} <= {prio[win_idx], win_idx}))
                    else $error("mailbox %0d beats winner", j);
            end
        end
    end

endmodule

// File: rtl/txarb_regs.sv
// Mailbox state: enable, direction, mask, pending, acknowledge and control fields.
module txarb_regs
    import txarb_pkg::*;
#(
    parameter int N_MBOX = 32,
    localparam int IDX_W = $clog2(N_MBOX)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en_wr,
    input  logic [N_MBOX-1:0]              en_wdata,
    input  logic                           dir_wr,
    input  logic [N_MBOX-1:0]              dir_wdata,
    input  logic                           mask_wr,
    input  logic [N_MBOX-1:0]              mask_wdata,
    input  logic                           ctrl_wr,
    input  logic [IDX_W-1:0]               ctrl_sel,
    input  logic [CTRL_W-1:0]              ctrl_wdata,
    input  logic                           req_set_wr,
    input  logic [N_MBOX-1:0]              req_set_data,
    input  logic                           ack_clr_wr,
    input  logic [N_MBOX-1:0]              ack_clr_data,
    input  logic                           cmp_done,
    input  logic                           cmp_abort,
    input  logic [IDX_W-1:0]               cmp_idx,
    output logic [N_MBOX-1:0]              en_q,
    output logic [N_MBOX-1:0]              dir_q,
    output logic [N_MBOX-1:0]              mask_q,
    output logic [N_MBOX-1:0]              pend_q,
    output logic [N_MBOX-1:0]              ack_q,
    output logic [N_MBOX-1:0][PRIO_W-1:0]  prio_q,
    output logic [N_MBOX-1:0][LEN_W-1:0]   len_q,
    output logic [N_MBOX-1:0]              rtr_q
);

    typedef struct packed {
        logic [N_MBOX-1:0]             en;
        logic [N_MBOX-1:0]             dir;
        logic [N_MBOX-1:0]             mask;
        logic [N_MBOX-1:0]             pend;
        logic [N_MBOX-1:0]             ack;
        logic [N_MBOX-1:0][PRIO_W-1:0] prio;
        logic [N_MBOX-1:0][LEN_W-1:0]  len;
        logic [N_MBOX-1:0]             rtr;
    } regs_t;

    regs_t st_d, st_q;

    logic [SPARE_W-1:0] unused_spare_bits;
    assign unused_spare_bits = ctrl_wdata[RTR_BIT+1 +: SPARE_W];

    always_comb begin
        st_d = st_q;
        if (en_wr)   st_d.en   = en_wdata;
        if (dir_wr)  st_d.dir  = dir_wdata;
        if (mask_wr) st_d.mask = mask_wdata;
        if (ctrl_wr) begin
            st_d.prio[ctrl_sel] = ctrl_wdata[PRIO_LSB +: PRIO_W];
            st_d.len[ctrl_sel]  = ctrl_wdata[LEN_LSB +: LEN_W];
            st_d.rtr[ctrl_sel]  = ctrl_wdata[RTR_BIT];
        end
        // Acknowledge: software clear first, completion set wins
        if (ack_clr_wr) st_d.ack = st_d.ack & ~ack_clr_data;
        if (cmp_done) begin
            st_d.ack[cmp_idx]  = 1'b1;
            st_d.pend[cmp_idx] = 1'b0;
        end
        if (cmp_abort) st_d.pend[cmp_idx] = 1'b0;
        // Pending: a new request wins over completion of the same mailbox
        if (req_set_wr) st_d.pend = st_d.pend | req_set_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign dir_q  = st_q.dir;
    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;
    assign ack_q  = st_q.ack;
    assign prio_q = st_q.prio;
    assign len_q  = st_q.len;
    assign rtr_q  = st_q.rtr;

    p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_done && !cmp_abort) |=> (($past(pend_q) & ~pend_q) == '0))
        else $error("pending bit dropped without completion");

    p_done_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |=> ack_q[$past(cmp_idx)])
        else $error("acknowledge not set on completion");

    p_done_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && !(req_set_wr && req_set_data[cmp_idx])) |=> !pend_q[$past(cmp_idx)])
        else $error("pending not cleared on completion");

    p_abort_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_abort && !(req_set_wr && req_set_data[cmp_idx])) |=> !pend_q[$past(cmp_idx)])
        else $error("pending not cleared on abort");

    p_abort_noack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_abort && !(ack_clr_wr && ack_clr_data[cmp_idx]))
        |=> (ack_q[$past(cmp_idx)] == $past(ack_q[cmp_idx])))
        else $error("abort changed acknowledge");

    p_ack_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr_wr && !cmp_done) |=> ((ack_q & $past(ack_clr_data)) == '0))
        else $error("acknowledge clear ignored");

endmodule

// File: rtl/txarb_ctrl.sv
// Hand-off state: holds the selected mailbox until the serializer answers.
module txarb_ctrl #(
    parameter int N_MBOX = 32,
    localparam int IDX_W = $clog2(N_MBOX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             ser_done,
    input  logic             ser_abort,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cmp_done,
    output logic             cmp_abort
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d     = sel_q;
        cmp_done  = sel_q.busy && ser_done;
        cmp_abort = sel_q.busy && ser_abort && !ser_done;
        if (!sel_q.busy) begin
            if (win_valid) begin
                sel_d.busy = 1'b1;
                sel_d.idx  = win_idx;
            end
        end else if (ser_done || ser_abort) begin
            sel_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign busy_o = sel_q.busy;
    assign idx_o  = sel_q.idx;

    p_hold_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ser_done && !ser_abort) |=> (busy_o && $stable(idx_o)))
        else $error("selection changed before response");

    p_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && win_valid) |=> busy_o)
        else $error("eligible mailbox not started");

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (ser_done || ser_abort)) |=> !busy_o)
        else $error("selection not released");

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !win_valid) |=> !busy_o)
        else $error("started with nothing eligible");

endmodule

// File: rtl/tx_mbox_arbiter.sv
module tx_mbox_arbiter
    import txarb_pkg::*;
#(
    parameter int N_MBOX = 32,
    localparam int IDX_W = $clog2(N_MBOX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [N_MBOX-1:0] en_wdata,
    input  logic              dir_wr,
    input  logic [N_MBOX-1:0] dir_wdata,
    input  logic              mask_wr,
    input  logic [N_MBOX-1:0] mask_wdata,
    input  logic              ctrl_wr,
    input  logic [IDX_W-1:0]  ctrl_sel,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              req_set_wr,
    input  logic [N_MBOX-1:0] req_set_data,
    input  logic              ack_clr_wr,
    input  logic [N_MBOX-1:0] ack_clr_data,
    output logic              ser_valid,
    output logic [IDX_W-1:0]  ser_idx,
    output logic [LEN_W-1:0]  ser_len,
    output logic              ser_rtr,
    input  logic              ser_done,
    input  logic              ser_abort,
    output logic [N_MBOX-1:0] pend_o,
    output logic [N_MBOX-1:0] ack_o,
    output logic              mbx_irq
);

    logic [N_MBOX-1:0]             en_q, dir_q, mask_q, pend_q, ack_q, rtr_q;
    logic [N_MBOX-1:0][PRIO_W-1:0] prio_q;
    logic [N_MBOX-1:0][LEN_W-1:0]  len_q;
    logic [N_MBOX-1:0]             elig;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    logic                          cmp_done, cmp_abort;

    txarb_regs #(.N_MBOX(N_MBOX)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_sel(ctrl_sel), .ctrl_wdata(ctrl_wdata),
        .req_set_wr(req_set_wr), .req_set_data(req_set_data),
        .ack_clr_wr(ack_clr_wr), .ack_clr_data(ack_clr_data),
        .cmp_done(cmp_done), .cmp_abort(cmp_abort), .cmp_idx(ser_idx),
        .en_q(en_q), .dir_q(dir_q), .mask_q(mask_q),
        .pend_q(pend_q), .ack_q(ack_q),
        .prio_q(prio_q), .len_q(len_q), .rtr_q(rtr_q)
    );

    assign elig = pend_q & en_q & ~dir_q;

    txarb_select #(.N_MBOX(N_MBOX)) u_sel (
        .rst_n(rst_n), .elig(elig), .prio(prio_q),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    txarb_ctrl #(.N_MBOX(N_MBOX)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_idx(win_idx),
        .ser_done(ser_done), .ser_abort(ser_abort),
        .busy_o(ser_valid), .idx_o(ser_idx),
        .cmp_done(cmp_done), .cmp_abort(cmp_abort)
    );

    assign ser_len = len_q[ser_idx];
    assign ser_rtr = rtr_q[ser_idx];
    assign pend_o  = pend_q;
    assign ack_o   = ack_q;
    assign mbx_irq = |(ack_q & mask_q);

    p_pick_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> (|($past(elig) & (N_MBOX'(1) << ser_idx))))
        else $error("presented mailbox was not eligible");

endmodule

// File: tb/sim_tx_mbox_arbiter.sv
`timescale 1ns/1ps
module sim_tx_mbox_arbiter;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          en_wr = 0, dir_wr = 0, mask_wr = 0, ctrl_wr = 0;
    logic          req_set_wr = 0, ack_clr_wr = 0, ser_done = 0, ser_abort = 0;
    logic [N-1:0]  en_wdata = 0, dir_wdata = 0, mask_wdata = 0;
    logic [N-1:0]  req_set_data = 0, ack_clr_data = 0;
    logic [4:0]    ctrl_sel = 0;
    logic [13:0]   ctrl_wdata = 0;
    logic          ser_valid, ser_rtr, mbx_irq;
    logic [4:0]    ser_idx;
    logic [3:0]    ser_len;
    logic [N-1:0]  pend_o, ack_o;

    tx_mbox_arbiter #(.N_MBOX(N)) u0 (.*);

    // Reference model
    logic [N-1:0] m_en = 0, m_dir = 0, m_mask = 0, m_pend = 0, m_ack = 0;
    logic [13:0]  m_ctrl [N];
    int errs = 0, checks = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic void exp_win(output bit ok, output int idx);
        int best;
        ok = 0; idx = 0; best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_en[i] && !m_dir[i] && int'(m_ctrl[i][13:8]) >= best) begin
                best = int'(m_ctrl[i][13:8]);
                idx = i;
                ok = 1;
            end
        end
    endfunction

    task automatic wr_en(input logic [N-1:0] v);
        en_wr = 1; en_wdata = v; cyc(); en_wr = 0; m_en = v;
    endtask
    task automatic wr_dir(input logic [N-1:0] v);
        dir_wr = 1; dir_wdata = v; cyc(); dir_wr = 0; m_dir = v;
    endtask
    task automatic wr_mask(input logic [N-1:0] v);
        mask_wr = 1; mask_wdata = v; cyc(); mask_wr = 0; m_mask = v;
    endtask
    task automatic wr_ctrl(input int i, input logic [13:0] v);
        ctrl_wr = 1; ctrl_sel = 5'(i); ctrl_wdata = v; cyc(); ctrl_wr = 0; m_ctrl[i] = v;
    endtask
    task automatic wr_req(input logic [N-1:0] v);
        req_set_wr = 1; req_set_data = v; cyc(); req_set_wr = 0; m_pend = m_pend | v;
    endtask
    task automatic wr_ackclr(input logic [N-1:0] v);
        ack_clr_wr = 1; ack_clr_data = v; cyc(); ack_clr_wr = 0; m_ack = m_ack & ~v;
    endtask

    // Check the presented mailbox against the model (R1, R2, R3, R10, R12)
    task automatic check_sel(output bit ok);
        int idx;
        exp_win(ok, idx);
        check("R12/R1 ser_valid", 32'(ser_valid), 32'(ok));
        if (ok && ser_valid) begin
            check("R2/R3 ser_idx", 32'(ser_idx), 32'(idx));
            check("R10 ser_len", 32'(ser_len), 32'(m_ctrl[idx][3:0]));
            check("R10 ser_rtr", 32'(ser_rtr), 32'(m_ctrl[idx][4]));
        end
    endtask

    // Keep the selection held while new requests arrive (R5)
    task automatic hold(input int n, input logic [N-1:0] setw);
        logic [4:0] held;
        held = ser_idx;
        for (int k = 0; k < n; k++) begin
            req_set_wr = 1; req_set_data = setw;
            cyc();
            req_set_wr = 0; m_pend = m_pend | setw;
            check("R5 held valid", 32'(ser_valid), 32'd1);
            check("R5 held idx", 32'(ser_idx), 32'(held));
        end
    endtask

    // Serializer response with optional same-cycle set and clear (R6, R7, R8, R9)
    task automatic respond(input bit done, input logic [N-1:0] setw, input logic [N-1:0] clrw);
        int idx;
        idx = int'(ser_idx);
        ser_done = done; ser_abort = !done;
        req_set_wr = (setw != 0); req_set_data = setw;
        ack_clr_wr = (clrw != 0); ack_clr_data = clrw;
        cyc();
        ser_done = 0; ser_abort = 0; req_set_wr = 0; ack_clr_wr = 0;
        m_ack = m_ack & ~clrw;
        if (done) m_ack[idx] = 1'b1;
        m_pend[idx] = 1'b0;
        m_pend = m_pend | setw;
        check("R6 valid drops", 32'(ser_valid), 32'd0);
        check(done ? "R6/R4 pending" : "R7/R4 pending", pend_o, m_pend);
        check(done ? "R6/R8 ack" : "R7/R8 ack", ack_o, m_ack);
        check("R9 irq", 32'(mbx_irq), 32'(|(m_ack & m_mask)));
    endtask

    task automatic drain(input bit rnd);
        bit ok;
        for (int g = 0; g < 80; g++) begin
            cyc();
            check_sel(ok);
            if (!ok) break;
            if (rnd) begin
                hold(int'($urandom_range(0, 2)),
                     ($urandom_range(0, 7) == 0) ? (N'(1) << $urandom_range(0, N-1)) : '0);
                respond($urandom_range(0, 3) != 0,
                        ($urandom_range(0, 9) == 0) ? (N'(1) << ser_idx) : '0,
                        ($urandom_range(0, 1) == 0) ? N'($urandom) : '0);
            end else begin
                respond(1'b1, '0, '0);
            end
        end
    endtask

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_ctrl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        check("R11 ser_valid", 32'(ser_valid), 32'd0);
        check("R11 pend", pend_o, 32'd0);
        check("R11 ack", ack_o, 32'd0);
        check("R11 irq", 32'(mbx_irq), 32'd0);

        // Directed: tie break, priority, hold, abort, same-cycle cases
        wr_mask('1);
        wr_ctrl(3,  {6'd10, 3'b000, 1'b0, 4'd2});
        wr_ctrl(9,  {6'd10, 3'b000, 1'b1, 4'd8});
        wr_ctrl(5,  {6'd9,  3'b000, 1'b0, 4'd5});
        wr_ctrl(31, {6'd63, 3'b000, 1'b1, 4'd1});
        wr_req(32'h0000_0228);
        wr_en('1);
        cyc();
        check_sel(ok);
        check("R3 tie picks higher index", 32'(ser_idx), 32'd9);
        hold(3, 32'h8000_0000);                           // R5: higher priority waits
        respond(1'b1, '0, 32'h0000_0200);                 // R8: set wins over clear
        check("R8 set beats clear", 32'(ack_o[9]), 32'd1);
        cyc();
        check_sel(ok);
        check("R2 highest priority", 32'(ser_idx), 32'd31);
        respond(1'b0, '0, '0);                            // R7: abort, no ack
        check("R7 abort leaves ack clear", 32'(ack_o[31]), 32'd0);
        cyc();
        check_sel(ok);
        check("R3 next tie member", 32'(ser_idx), 32'd3);
        respond(1'b1, 32'h0000_0008, '0);                 // R6: set during completion keeps pending
        check("R6 set during done keeps pending", 32'(pend_o[3]), 32'd1);
        drain(1'b0);

        // R9 masking and R8 clear
        wr_mask(32'h0000_0008);
        check("R9 masked irq", 32'(mbx_irq), 32'(|(m_ack & 32'h8)));
        wr_ackclr('1);
        check("R8 all cleared", ack_o, 32'd0);
        check("R9 irq low", 32'(mbx_irq), 32'd0);

        // R4 zero write, R1 disabled and receive mailboxes
        wr_en('0);
        wr_dir(32'h0000_00F0);
        wr_req('0);
        check("R4 zero write no effect", pend_o, m_pend);
        wr_req(32'h0000_0FF0);
        wr_en(32'h0000_00F0);
        cyc();
        check("R1 rx and disabled not presented", 32'(ser_valid), 32'd0);
        check("R1 pending kept", pend_o, m_pend);

        // Random rounds
        for (int it = 0; it < 150; it++) begin
            wr_en('0);
            wr_dir(N'($urandom) & N'($urandom));
            wr_mask(N'($urandom));
            for (int c = 0; c < 4; c++)
                wr_ctrl(int'($urandom_range(0, N-1)),
                        14'($urandom) & (($urandom_range(0, 2) == 0) ? 14'h0F1F : 14'h3F1F));
            wr_req(N'($urandom) & N'($urandom));
            wr_en(N'($urandom) | N'($urandom));
            drain(1'b1);
            check("R4/R1 pending after round", pend_o, m_pend);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++; checks++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule